// File: doc/BRIEF.md
# Grid Protection and Reconnection Supervisor

This block watches an inverter's measurements once per supervision tick (nominally 1 kHz) and decides two things: whether the power bridge must be shut off now, and whether the inverter may ask to join the grid. Two kinds of fault are handled.

A hard fault is a DC bus overvoltage or an output current beyond its magnitude limit. A hard fault trips the bridge on the tick where it is seen. A soft fault is grid RMS voltage outside its window, frequency offset outside its band, or DC bus undervoltage. A soft fault only drains a leaky health counter. The counter trips the bridge when it drops below an OK level while the bridge runs. The same counter holds off reconnection until it has climbed back to its ceiling.

The causes of faults are gathered in a sticky five-bit error code. That code is cleared only when a join request is raised. The measurements and thresholds are signed words that upstream logic supplies. Unit scaling is up to the user. For example, RMS limits of 208 and 255, and a frequency offset band of ±50 in 0.01 Hz steps.

Top module: `grid_guard`

## Requirements
- R1: All inputs are sampled only on a cycle where `tick` is high. `trip` and `join_req` are one-cycle pulses in the cycle after such a tick, and are low at all other times. Between ticks, no input changes `err_code`.
- R2: When `bus_v > bus_max`, `trip` pulses, the health counter is forced to its floor, and `err_code[0]` is set. A value equal to `bus_max` is not a fault.
- R3: When `out_i > cur_lim` or `out_i < -cur_lim`, `trip` pulses, the counter is forced to its floor, and `err_code[1]` is set. A value equal to the limit in either polarity is not a fault.
- R4: When `grid_rms > rms_hi` or `grid_rms < rms_lo`, `FAIL_STEP` is subtracted from the counter and `err_code[2]` is set. The limits themselves are inside the window.
- R5: When `freq_off > freq_dev` or `freq_off < -freq_dev`, `FAIL_STEP` is subtracted and `err_code[3]` is set.
- R6: When `bus_v < bus_min`, `FAIL_STEP` is subtracted and `err_code[4]` is set. Each soft fault that is present subtracts `FAIL_STEP` independently.
- R7: When `bridge_on` is high and the counter after the subtractions is below `OK_LEVEL`, `trip` pulses and the counter is forced to its floor. With `bridge_on` low, no such trip occurs.
- R8: When `bridge_on` is low, `join_en` is high, and the counter (before the end-of-tick increment) equals `CNT_CEIL`, `join_req` pulses and `err_code` is cleared to zero. With `join_en` low, no request is raised.
- R9: At the end of every tick, the counter is incremented by one and then clamped to [`CNT_FLOOR`, `CNT_CEIL`]. After a floor-forcing tick, a fault-free recovery with the bridge off raises `join_req` on the (`CNT_CEIL`-`CNT_FLOOR`)-th tick.
- R10: Hard faults take priority. A tick that trips never raises `join_req` as well.
- R11: Error bits accumulate across ticks and are cleared only by a join request.
- R12: After reset, `trip` and `join_req` are low, `err_code` is zero, and the counter is at `CNT_FLOOR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Supervision strobe, one cycle wide |
| bus_v | input | MEAS_W | DC bus voltage, signed |
| out_i | input | MEAS_W | Output current, signed |
| grid_rms | input | MEAS_W | Grid RMS voltage, signed |
| freq_off | input | MEAS_W | Grid frequency offset from nominal, signed |
| bus_max | input | MEAS_W | Bus overvoltage threshold |
| bus_min | input | MEAS_W | Bus undervoltage threshold |
| cur_lim | input | MEAS_W | Current magnitude limit, non-negative |
| rms_hi | input | MEAS_W | Upper RMS limit |
| rms_lo | input | MEAS_W | Lower RMS limit |
| freq_dev | input | MEAS_W | Allowed frequency offset magnitude, non-negative |
| join_en | input | 1 | Permission to request grid connection |
| bridge_on | input | 1 | Bridge currently switching |
| trip | output | 1 | Bridge-disable pulse |
| join_req | output | 1 | Grid-join request pulse |
| err_code | output | 5 | Sticky causes: bit0 bus over, bit1 current, bit2 RMS, bit3 frequency, bit4 bus under |

## Verification
The bench shrinks the counter to `CNT_FLOOR`=0, `CNT_CEIL`=6, `OK_LEVEL`=3 and `FAIL_STEP`=3. At these values one soft fault leaves a running bridge just above the OK level, and two soft faults in one tick drop it below that level. A persistent single fault trips on its second tick. The hidden counter value after any tick can be read from the number of fault-free ticks until `join_req`. Such a recovery is at most seven ticks long, so every row of the vector table can be followed by a full recovery. The same is true of the clamp at the floor.

// File: rtl/grid_guard.sv
module grid_guard #(
  parameter int MEAS_W    = 16,
  parameter int CNT_W     = 10,
  parameter int CNT_FLOOR = 0,
  parameter int CNT_CEIL  = 200,
  parameter int OK_LEVEL  = 100,
  parameter int FAIL_STEP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic signed [MEAS_W-1:0] bus_v,
  input  logic signed [MEAS_W-1:0] out_i,
  input  logic signed [MEAS_W-1:0] grid_rms,
  input  logic signed [MEAS_W-1:0] freq_off,
  input  logic signed [MEAS_W-1:0] bus_max,
  input  logic signed [MEAS_W-1:0] bus_min,
  input  logic signed [MEAS_W-1:0] cur_lim,
  input  logic signed [MEAS_W-1:0] rms_hi,
  input  logic signed [MEAS_W-1:0] rms_lo,
  input  logic signed [MEAS_W-1:0] freq_dev,
  input  logic                     join_en,
  input  logic                     bridge_on,
  output logic                     trip,
  output logic                     join_req,
  output logic [4:0]               err_code
);
  localparam int AW = CNT_W + 4;
  localparam int XW = MEAS_W + 1;
  localparam logic signed [AW-1:0] FLOOR_A = AW'(CNT_FLOOR);
  localparam logic signed [AW-1:0] CEIL_A  = AW'(CNT_CEIL);
  localparam logic signed [AW-1:0] OK_A    = AW'(OK_LEVEL);

  logic signed [CNT_W-1:0] health;

  logic signed [XW-1:0] i_x, lim_x, f_x, dev_x;
  assign i_x   = XW'(out_i);
  assign lim_x = XW'(cur_lim);
  assign f_x   = XW'(freq_off);
  assign dev_x = XW'(freq_dev);

  logic bus_hi, cur_bad, rms_bad, frq_bad, bus_lo, hard;
  assign bus_hi  = bus_v > bus_max;
  assign cur_bad = (i_x > lim_x) || (i_x < -lim_x);
  assign rms_bad = (grid_rms > rms_hi) || (grid_rms < rms_lo);
  assign frq_bad = (f_x > dev_x) || (f_x < -dev_x);
  assign bus_lo  = bus_v < bus_min;
  assign hard    = bus_hi || cur_bad;

  logic [1:0] n_soft;
  assign n_soft = {1'b0, rms_bad} + {1'b0, frq_bad} + {1'b0, bus_lo};

  logic signed [AW-1:0] drain, h_sub, h_inc, h_nxt;
  logic                 soft_trip, do_trip, do_join;

  assign drain     = AW'(FAIL_STEP) * AW'(n_soft);
  assign h_sub     = hard ? FLOOR_A : (AW'(health) - drain);
  assign soft_trip = bridge_on && (h_sub < OK_A);
  assign do_trip   = hard || soft_trip;
  assign do_join   = !do_trip && !bridge_on && join_en && (h_sub == CEIL_A);
  assign h_inc     = (do_trip ? FLOOR_A : h_sub) + AW'(1);

  always_comb begin
    if (h_inc > CEIL_A)       h_nxt = CEIL_A;
    else if (h_inc < FLOOR_A) h_nxt = FLOOR_A;
    else                      h_nxt = h_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      health   <= CNT_W'(CNT_FLOOR);
      trip     <= 1'b0;
      join_req <= 1'b0;
      err_code <= '0;
    end else begin
      trip     <= tick && do_trip;
      join_req <= tick && do_join;
      if (tick) begin
        health <= CNT_W'(h_nxt);
        if (do_join) err_code <= '0;
        else         err_code <= err_code | {bus_lo, frq_bad, rms_bad, cur_bad, bus_hi};
      end
    end
  end

  assert_pulse_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trip || join_req) |-> $past(tick));

  assert_bus_over_trips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && bus_v > bus_max) |=> (trip && err_code[0]));

  assert_cur_over_trips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && out_i > cur_lim) |=> (trip && err_code[1]));

  assert_health_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (health >= CNT_W'(CNT_FLOOR)) && (health <= CNT_W'(CNT_CEIL)));

  assert_join_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    join_req |-> ($past(join_en) && !$past(bridge_on) && err_code == 5'd0));

  assert_no_join_with_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(trip && join_req));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !join_req |-> ((err_code & $past(err_code)) == $past(err_code)));
endmodule

// File: tb/grid_guard_bench.sv
module grid_guard_bench;
  localparam int MW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic signed [MW-1:0] bus_v, out_i, grid_rms, freq_off;
  logic signed [MW-1:0] bus_max, bus_min, cur_lim, rms_hi, rms_lo, freq_dev;
  logic join_en, bridge_on;
  logic trip, join_req;
  logic [4:0] err_code;

  always #5 clk = ~clk;

  grid_guard #(.MEAS_W(MW), .CNT_W(6), .CNT_FLOOR(0), .CNT_CEIL(6),
               .OK_LEVEL(3), .FAIL_STEP(3)) u_grid_guard (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_v(bus_v), .out_i(out_i),
    .grid_rms(grid_rms), .freq_off(freq_off), .bus_max(bus_max), .bus_min(bus_min),
    .cur_lim(cur_lim), .rms_hi(rms_hi), .rms_lo(rms_lo), .freq_dev(freq_dev),
    .join_en(join_en), .bridge_on(bridge_on), .trip(trip), .join_req(join_req),
    .err_code(err_code));

  typedef struct packed {
    logic signed [15:0] bus, cur, rms, frq;
    logic               br, tr;
    logic [4:0]         er;
    logic [7:0]         wt;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{16'sd350,  16'sd10,   16'sd230,  16'sd0,   1'b1, 1'b0, 5'b00000, 8'd1},
    '{16'sd401,  16'sd10,   16'sd230,  16'sd0,   1'b1, 1'b1, 5'b00001, 8'd6},
    '{16'sd400,  16'sd10,   16'sd230,  16'sd0,   1'b1, 1'b0, 5'b00000, 8'd1},
    '{16'sd350,  16'sd101,  16'sd230,  16'sd0,   1'b1, 1'b1, 5'b00010, 8'd6},
    '{16'sd350, -16'sd101,  16'sd230,  16'sd0,   1'b1, 1'b1, 5'b00010, 8'd6},
    '{16'sd350, -16'sd100,  16'sd230,  16'sd0,   1'b1, 1'b0, 5'b00000, 8'd1},
    '{16'sd350,  16'sd10,   16'sd256,  16'sd0,   1'b1, 1'b0, 5'b00100, 8'd3},
    '{16'sd350,  16'sd10,   16'sd207,  16'sd0,   1'b1, 1'b0, 5'b00100, 8'd3},
    '{16'sd350,  16'sd10,   16'sd208,  16'sd50,  1'b1, 1'b0, 5'b00000, 8'd1},
    '{16'sd350,  16'sd10,   16'sd230,  16'sd51,  1'b1, 1'b0, 5'b01000, 8'd3},
    '{16'sd350,  16'sd10,   16'sd230, -16'sd51,  1'b1, 1'b0, 5'b01000, 8'd3},
    '{16'sd299,  16'sd10,   16'sd230,  16'sd0,   1'b1, 1'b0, 5'b10000, 8'd3},
    '{16'sd350,  16'sd10,   16'sd256,  16'sd51,  1'b1, 1'b1, 5'b01100, 8'd6},
    '{16'sd350,  16'sd10,   16'sd256,  16'sd51,  1'b0, 1'b0, 5'b01100, 8'd6},
    '{16'sd401,  16'sd10,   16'sd300,  16'sd0,   1'b0, 1'b1, 5'b00101, 8'd6}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nominal();
    bus_v = 16'sd350; out_i = 16'sd10; grid_rms = 16'sd230; freq_off = 16'sd0;
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic prime();
    do_reset();
    nominal(); bridge_on = 1'b0; join_en = 1'b0;
    repeat (7) do_tick();
  endtask

  task automatic recover(output int n);
    nominal(); bridge_on = 1'b0; join_en = 1'b1;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      do_tick();
      n++;
      if (join_req) break;
    end
  endtask

  initial begin
    int w;
    bus_max = 16'sd400; bus_min = 16'sd300; cur_lim = 16'sd100;
    rms_hi = 16'sd255; rms_lo = 16'sd208; freq_dev = 16'sd50;
    nominal(); join_en = 1'b0; bridge_on = 1'b0;

    do_reset();
    chk("R12 trip", int'(trip), 0);
    chk("R12 join_req", int'(join_req), 0);
    chk("R12 err_code", int'(err_code), 0);

    for (int v = 0; v < 15; v++) begin
      prime();
      bus_v = VEC[v].bus; out_i = VEC[v].cur; grid_rms = VEC[v].rms; freq_off = VEC[v].frq;
      bridge_on = VEC[v].br;
      do_tick();
      chk($sformatf("R2/R3/R7 trip vec %0d", v), int'(trip), int'(VEC[v].tr));
      chk($sformatf("R4/R5/R6 err vec %0d", v), int'(err_code), int'(VEC[v].er));
      chk($sformatf("R10 no join vec %0d", v), int'(join_req), 0);
      @(negedge clk);
      chk($sformatf("R1 pulse width vec %0d", v), int'(trip), 0);
      recover(w);
      chk($sformatf("R9 recovery ticks vec %0d", v), w, int'(VEC[v].wt));
      chk($sformatf("R8 err cleared vec %0d", v), int'(err_code), 0);
    end

    prime();
    bus_v = 16'sd401; bridge_on = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 no trip without tick", int'(trip), 0);
    chk("R1 no err without tick", int'(err_code), 0);

    prime();
    bridge_on = 1'b1; grid_rms = 16'sd256;
    do_tick();
    chk("R7 first soft tick no trip", int'(trip), 0);
    do_tick();
    chk("R7 second soft tick trips", int'(trip), 1);
    chk("R11 err held", int'(err_code), 5'b00100);
    nominal(); bridge_on = 1'b0; join_en = 1'b0;
    do_tick();
    chk("R11 err still held", int'(err_code), 5'b00100);

    prime();
    bridge_on = 1'b0; join_en = 1'b1; bus_v = 16'sd401;
    do_tick();
    chk("R10 trip at ceiling", int'(trip), 1);
    chk("R10 join blocked", int'(join_req), 0);

    prime();
    bridge_on = 1'b0; join_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      do_tick();
      chk("R8 join_en low blocks", int'(join_req), 0);
    end
    join_en = 1'b1;
    do_tick();
    chk("R8 join when enabled", int'(join_req), 1);

    prime();
    bridge_on = 1'b0; join_en = 1'b0; grid_rms = 16'sd256; freq_off = 16'sd51;
    do_tick();
    do_tick();
    chk("R7 no soft trip with bridge off", int'(trip), 0);
    recover(w);
    chk("R9 clamp at floor", w, 7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule